// File: doc/BRIEF.md
# Multi-Domain Reset Line Controller

This block holds the software-programmed requested state of a large set of reset lines and drives those lines into several clock domains. Lines come in groups of 32. Each group has one assert register, in which bit n of group m requests line 32*m + n (1 = hold in reset, 0 = release). Each group also has one status register that reports what the target domain actually sees. Software changes a single line with a read-modify-write of the assert register. It then polls the matching status bit until that bit shows the new state.

The status path runs through a two-flop capture stage clocked by the target domain's clock. That stage advances only while the domain's clock enable is high. While a domain is gated, its lines and their status freeze, and a pending release stays pending. Each status bit has a fixed polarity set at build time. Most lines read 0 while held in reset and 1 once released. A few lines read 1 while held in reset.

The address has two parts. Bits [13:12] select a domain window, and bits [11:0] are the offset inside it. By default the main domain (window 0) holds four groups. Windows 1 and 2 each hold one group. Reads of unmapped addresses return zero. Writes to status registers or unmapped addresses change nothing.

Top module: `rst_line_ctrl`

## Requirements
- R1: After rst_ni is released, every assert register reads 0xFFFFFFFF, every line on rst_line_o is 1 (held in reset), and each status register reads its held-in-reset pattern. For group 0 that pattern is 0x0000003F.
- R2: A write (req_i=1, we_i=1) to an assert register takes effect on that clock edge. Afterwards the register reads back exactly the last value written. Assert offsets are 0x2F8, 0x2FC, 0x300 and 0x304 in window 0 (groups 0 to 3), 0x074 in window 1 (group 4) and 0x038 in window 2 (group 5).
- R3: rst_line_o[32*m+n] equals bit n of assert register m two enabled domain-clock edges after the register changes.
- R4: Status register m reads line state XOR the inversion mask. Inverted lines read 0 in reset and 1 when released. Non-inverted lines are group 0 bits 5:0 and group 4 bits 3:2. Status offsets are 0x308, 0x30C, 0x310 and 0x314 in window 0, 0x078 in window 1 and 0x03C in window 2.
- R5: While dom_en_i[d] is low, the lines and status bits of domain d hold their value. After the enable returns high, they reach the requested state two edges later.
- R6: A read of any address that maps to no assert or status register returns 0.
- R7: A write to a status register or to an unmapped address leaves every assert register and every line unchanged.
- R8: An offset only matches inside its own domain window. For example, 0x1308 (window 1, offset 0x308) is unmapped.
- R9: Gating one domain does not delay lines in any other domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high with req_i |
| addr_i | input | 14 | Domain window [13:12] and offset [11:0] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| dom_clk_i | input | 3 | Clock of each target domain |
| dom_en_i | input | 3 | Clock enable of each target domain |
| rst_line_o | output | 192 | Reset lines, 1 = held in reset |

## Verification
An assert register write is visible on rdata_o right after the edge that accepts it. The lines and status bits follow two enabled domain edges later, so scripted checks wait three edges after a write before sampling. The bench keeps a behavioural model that advances on every rising edge. It compares rst_line_o and rdata_o 6 ns after each edge, once the flops and the combinational read path have settled. Gated windows are checked by holding the enable low for several edges. The frozen value is compared first, then the delayed release after the enable returns.

// File: rtl/rst_line_pkg.sv
package rst_line_pkg;
  localparam int unsigned GRP_BITS = 32;
  typedef logic [GRP_BITS-1:0] grp_word_t;
endpackage

// File: rtl/rst_line_decode.sv
module rst_line_decode #(
  parameter int unsigned NUM_GRP = 6,
  parameter int unsigned OFS_W   = 12,
  parameter int unsigned DOM_W   = 2,
  parameter logic [NUM_GRP-1:0][OFS_W-1:0] ASRT_OFS = '0,
  parameter logic [NUM_GRP-1:0][OFS_W-1:0] STAT_OFS = '0,
  parameter logic [NUM_GRP-1:0][DOM_W-1:0] GRP_DOM  = '0
) (
  input  logic [OFS_W+DOM_W-1:0] addr_i,
  output logic [NUM_GRP-1:0]     asrt_hit_o,
  output logic [NUM_GRP-1:0]     stat_hit_o
);
  logic [DOM_W-1:0] win;
  logic [OFS_W-1:0] ofs;
  assign win = addr_i[OFS_W+DOM_W-1:OFS_W];
  assign ofs = addr_i[OFS_W-1:0];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
    logic in_win;
    assign in_win        = (win == GRP_DOM[g]);
    assign asrt_hit_o[g] = in_win && (ofs == ASRT_OFS[g]);
    assign stat_hit_o[g] = in_win && (ofs == STAT_OFS[g]);
  end
endmodule

// File: rtl/rst_line_regs.sv
module rst_line_regs
  import rst_line_pkg::*;
#(
  parameter int unsigned NUM_GRP = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [NUM_GRP-1:0]       hit_i,
  input  grp_word_t                wdata_i,
  output grp_word_t [NUM_GRP-1:0]  asrt_q_o
);
  grp_word_t [NUM_GRP-1:0] asrt_q;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                asrt_q[g] <= '1;
      else if (wr_i && hit_i[g])  asrt_q[g] <= wdata_i;
    end

    a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && hit_i[g]) |=> (asrt_q_o[g] == $past(wdata_i)));
  end

  assign asrt_q_o = asrt_q;

  a_r7_stray_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !(|hit_i)) |=> $stable(asrt_q_o));
endmodule

// File: rtl/rst_line_sync.sv
module rst_line_sync
  import rst_line_pkg::*;
(
  input  logic      dclk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  grp_word_t req_i,
  output grp_word_t line_o
);
  grp_word_t stage1, stage2;

  // both stages reset to "held", advance only while the domain clock is enabled
  always_ff @(posedge dclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1 <= '1;
      stage2 <= '1;
    end else if (en_i) begin
      stage1 <= req_i;
      stage2 <= stage1;
    end
  end

  assign line_o = stage2;

  a_r5_hold_when_gated: assert property (@(posedge dclk_i) disable iff (!rst_ni)
    !en_i |=> $stable(line_o));

  a_r3_two_stage_follow: assert property (@(posedge dclk_i) disable iff (!rst_ni)
    en_i |=> (line_o == $past(stage1)));
endmodule

// File: rtl/rst_line_rdmux.sv
module rst_line_rdmux
  import rst_line_pkg::*;
#(
  parameter int unsigned NUM_GRP = 6,
  parameter logic [NUM_GRP-1:0][GRP_BITS-1:0] STAT_INV = '1
) (
  input  logic [NUM_GRP-1:0]       asrt_hit_i,
  input  logic [NUM_GRP-1:0]       stat_hit_i,
  input  grp_word_t [NUM_GRP-1:0]  asrt_q_i,
  input  grp_word_t [NUM_GRP-1:0]  line_i,
  output grp_word_t                rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (asrt_hit_i[g]) rdata_o = rdata_o | asrt_q_i[g];
      if (stat_hit_i[g]) rdata_o = rdata_o | (line_i[g] ^ STAT_INV[g]);
    end
  end
endmodule

// File: rtl/rst_line_ctrl.sv
module rst_line_ctrl
  import rst_line_pkg::*;
#(
  parameter int unsigned NUM_GRP = 6,
  parameter int unsigned NUM_DOM = 3,
  parameter int unsigned OFS_W   = 12,
  parameter int unsigned DOM_W   = 2,
  parameter logic [NUM_GRP-1:0][OFS_W-1:0] ASRT_OFS =
    {12'h038, 12'h074, 12'h304, 12'h300, 12'h2FC, 12'h2F8},
  parameter logic [NUM_GRP-1:0][OFS_W-1:0] STAT_OFS =
    {12'h03C, 12'h078, 12'h314, 12'h310, 12'h30C, 12'h308},
  parameter logic [NUM_GRP-1:0][DOM_W-1:0] GRP_DOM  =
    {2'd2, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0},
  parameter logic [NUM_GRP-1:0][31:0] STAT_INV =
    {32'hFFFF_FFFF, 32'hFFFF_FFF3, 32'hFFFF_FFFF,
     32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFC0}
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [OFS_W+DOM_W-1:0]    addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  input  logic [NUM_DOM-1:0]        dom_clk_i,
  input  logic [NUM_DOM-1:0]        dom_en_i,
  output logic [NUM_GRP*32-1:0]     rst_line_o
);
  logic [NUM_GRP-1:0]      asrt_hit, stat_hit;
  grp_word_t [NUM_GRP-1:0] asrt_q, line;
  logic                    wr;

  assign wr = req_i && we_i;

  rst_line_decode #(
    .NUM_GRP(NUM_GRP), .OFS_W(OFS_W), .DOM_W(DOM_W),
    .ASRT_OFS(ASRT_OFS), .STAT_OFS(STAT_OFS), .GRP_DOM(GRP_DOM)
  ) u_decode (
    .addr_i    (addr_i),
    .asrt_hit_o(asrt_hit),
    .stat_hit_o(stat_hit)
  );

  rst_line_regs #(.NUM_GRP(NUM_GRP)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .hit_i   (asrt_hit),
    .wdata_i (wdata_i),
    .asrt_q_o(asrt_q)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_sync
    rst_line_sync u_sync (
      .dclk_i(dom_clk_i[GRP_DOM[g]]),
      .rst_ni(rst_ni),
      .en_i  (dom_en_i[GRP_DOM[g]]),
      .req_i (asrt_q[g]),
      .line_o(line[g])
    );
  end

  rst_line_rdmux #(.NUM_GRP(NUM_GRP), .STAT_INV(STAT_INV)) u_rdmux (
    .asrt_hit_i(asrt_hit),
    .stat_hit_i(stat_hit),
    .asrt_q_i  (asrt_q),
    .line_i    (line),
    .rdata_o   (rdata_o)
  );

  assign rst_line_o = line;

  // R8: one address maps to at most one register across all windows
  a_r8_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({asrt_hit, stat_hit}));

  a_r6_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|{asrt_hit, stat_hit}) |-> (rdata_o == 32'h0));
endmodule

// File: tb/rst_line_ctrl_bench.sv
module rst_line_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0] den = 3'b111;
  logic [191:0] lines;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit auto_on = 1'b0;

  always #4 clk = ~clk;

  rst_line_ctrl u_rst_line_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .dom_clk_i({clk, clk, clk}), .dom_en_i(den), .rst_line_o(lines)
  );

  // requirement tables (R2, R4)
  int unsigned t_asrt[6] = '{12'h2F8, 12'h2FC, 12'h300, 12'h304, 12'h074, 12'h038};
  int unsigned t_stat[6] = '{12'h308, 12'h30C, 12'h310, 12'h314, 12'h078, 12'h03C};
  int unsigned t_dom[6]  = '{0, 0, 0, 0, 1, 2};
  logic [31:0] t_inv[6]  = '{32'hFFFF_FFC0, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                             32'hFFFF_FFFF, 32'hFFFF_FFF3, 32'hFFFF_FFFF};

  // behavioural model
  logic [31:0] m_req[6], m_a[6], m_b[6];
  always @(posedge clk or negedge rst_n) begin
    for (int g = 0; g < 6; g++) begin
      if (!rst_n) begin
        m_req[g] <= '1; m_a[g] <= '1; m_b[g] <= '1;
      end else begin
        if (req && we && addr[13:12] == t_dom[g] && addr[11:0] == t_asrt[g])
          m_req[g] <= wdata;
        if (den[t_dom[g]]) begin
          m_a[g] <= m_req[g];
          m_b[g] <= m_a[g];
        end
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [13:0] a, output string tag);
    model_read = '0;
    tag = "R6";
    for (int g = 0; g < 6; g++) begin
      if (a[13:12] == t_dom[g] && a[11:0] == t_asrt[g]) begin
        model_read = m_req[g]; tag = "R2";
      end
      if (a[13:12] == t_dom[g] && a[11:0] == t_stat[g]) begin
        model_read = m_b[g] ^ t_inv[g]; tag = "R4";
      end
    end
  endfunction

  function automatic logic [191:0] model_lines();
    for (int g = 0; g < 6; g++) model_lines[g*32 +: 32] = m_b[g];
  endfunction

  task automatic chk(input string tag, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, 6 ns after each edge
  always @(posedge clk) begin
    #6;
    if (auto_on && !done) begin
      string tg;
      logic [31:0] e;
      e = model_read(addr, tg);
      chk(tg, {160'h0, rdata}, {160'h0, e});
      chk("R3", lines, model_lines());
    end
  end

  task automatic bus_wr(input logic [13:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [13:0] a, input logic [31:0] exp);
    @(posedge clk); #2;
    addr = a;
    #4;
    chk(tag, {160'h0, rdata}, {160'h0, exp});
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    auto_on = 1'b1;
    // R1 reset state
    rd_chk("R1", 14'h02F8, 32'hFFFF_FFFF);
    rd_chk("R1", 14'h0308, 32'h0000_003F);
    rd_chk("R1", 14'h203C, 32'h0000_0000);
    chk("R1", lines, {192{1'b1}});
    // R3/R4 release group 0
    bus_wr(14'h02F8, 32'h0000_0000);
    settle();
    rd_chk("R4", 14'h0308, 32'hFFFF_FFC0);
    chk("R3", {160'h0, lines[31:0]}, 192'h0);
    // R4 group 4 partial
    bus_wr(14'h1074, 32'hFFFF_FFF0);
    settle();
    rd_chk("R4", 14'h1078, 32'h0000_0003);
    // R5 gate window 2, R9 window 0 keeps moving
    @(posedge clk); #2 den = 3'b011;
    bus_wr(14'h2038, 32'h0000_0000);
    bus_wr(14'h02FC, 32'h0000_FFFF);
    repeat (5) @(posedge clk);
    rd_chk("R5", 14'h203C, 32'h0000_0000);
    chk("R5", {160'h0, lines[191:160]}, {160'h0, 32'hFFFF_FFFF});
    chk("R9", {160'h0, lines[63:32]}, {160'h0, 32'h0000_FFFF});
    @(posedge clk); #2 den = 3'b111;
    settle();
    rd_chk("R5", 14'h203C, 32'hFFFF_FFFF);
    chk("R5", {160'h0, lines[191:160]}, 192'h0);
    // R7 write to status and to unmapped addresses
    bus_wr(14'h0308, 32'hFFFF_FFFF);
    bus_wr(14'h0100, 32'h1234_5678);
    settle();
    rd_chk("R7", 14'h02F8, 32'h0000_0000);
    chk("R7", {160'h0, lines[31:0]}, 192'h0);
    rd_chk("R6", 14'h0100, 32'h0000_0000);
    rd_chk("R8", 14'h1308, 32'h0000_0000);
    rd_chk("R8", 14'h3074, 32'h0000_0000);
    // R2 readback with a pattern
    bus_wr(14'h0304, 32'hA5A5_5A5A);
    rd_chk("R2", 14'h0304, 32'hA5A5_5A5A);
    settle();
    rd_chk("R4", 14'h0314, 32'h5A5A_A5A5);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_600_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule